// File: doc/BRIEF.md
# Packed Binary64 to Unsigned 32-bit Integer Converter

This block takes a vector of up to eight IEEE 754 binary64 values and turns each into an unsigned 32-bit integer. All lanes convert in parallel through combinational lane converters. A single output register holds the packed 256-bit result, two exception flags and an encoding-fault bit. The result appears one clock after the operands are presented. There is no handshake: the operands are sampled on every rising clock edge and their result is presented on the next one.

A 2-bit length code selects how many lanes are active. Each active lane either gets its converted value or is handled by a per-lane write mask. Under the merge policy a masked lane keeps the prior destination value, and under the zero policy it is cleared. A lane's operand is either its own slice of the source vector or, for a memory-style broadcast, one shared 64-bit value.

Rounding normally follows a global mode. A per-operation override replaces it only when a register source is used at full length with the broadcast/override bit set. Values that cannot be represented return all ones and raise the invalid flag. The block is purely datapath plus one register rank, so it has no state machine. Its only sequential behaviour is the reset state and the one-cycle result register.

Top module: `pd2u_conv`

## Requirements
- R1: `vlen` selects the active lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes. Active lane j converts source bits [64j+63:64j] into result bits [32j+31:32j].
- R2: The rounding code is 2'b00 for nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero.
- R3: `rm_embed` replaces `rm_global` only when `vlen` selects 8 lanes, `bcst_rc_bit`=1 and `src_is_mem`=0. In every other case `rm_global` applies.
- R4: When `src_is_mem`=1 and `bcst_rc_bit`=1, every active lane converts `bcast_val`.
- R5: An active lane is written when `mask_en`=0 or `wr_mask[j]`=1. Otherwise it takes `prior_dst` lane j when `zero_mode`=0, and 0 when `zero_mode`=1.
- R6: NaN, infinity, a result of 2^32 or more after rounding, or a negative value that rounds to a nonzero magnitude all return 32'hFFFFFFFF and set `flag_invalid`.
- R7: `flag_inexact` is set when a written lane's valid result differs from its input. An invalid lane does not set it.
- R8: A negative input whose rounded magnitude is zero returns 0 without invalid. It is inexact unless the input is a zero.
- R9: Subnormal inputs always set inexact. They return 1 for positive inputs rounded toward plus infinity, are invalid for negative inputs rounded toward minus infinity, and return 0 otherwise.
- R10: Result lanes at and above the active lane count are 0 whatever the mask and prior value.
- R11: Only written lanes contribute to `flag_invalid` and `flag_inexact`.
- R12: `enc_fault` is 1 exactly when `resv_field` is not 4'b1111.
- R13: Outputs are registered: they show the operands of the previous rising edge, and they read 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vec | input | 512 | Eight binary64 source lanes |
| bcast_val | input | 64 | Shared binary64 operand for broadcast |
| src_is_mem | input | 1 | Source is memory-style (enables broadcast) |
| bcst_rc_bit | input | 1 | Broadcast bit (memory source) or override enable (register source) |
| vlen | input | 2 | Vector length code |
| mask_en | input | 1 | Write masking enabled |
| wr_mask | input | 8 | Per-lane write mask |
| zero_mode | input | 1 | 1 clears masked lanes, 0 merges |
| prior_dst | input | 256 | Prior destination value for merging |
| rm_global | input | 2 | Global rounding mode |
| rm_embed | input | 2 | Per-operation rounding override |
| resv_field | input | 4 | Reserved specifier field, must be 4'b1111 |
| res_q | output | 256 | Packed 32-bit results |
| flag_invalid | output | 1 | Invalid flag, OR over written lanes |
| flag_inexact | output | 1 | Inexact flag, OR over written lanes |
| enc_fault | output | 1 | Undefined-encoding fault |

## Verification
Several checks are made on every cycle after reset. These cover the zeroing of inactive upper lanes at the shortest length, the fault bit tracking the reserved field, and fully masked operations clearing or merging the whole result without raising flags. They also check that a full-length broadcast yields eight identical lanes. The numeric behaviour can only be shown by the bench's scenarios, which compare every lane against a reference built on real arithmetic. That behaviour covers ties-to-even, the four rounding directions, the override being honoured or ignored by length and source, the boundary at 2^32, negative values near zero, and subnormals.

// File: rtl/pd2u_pkg.sv
package pd2u_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    localparam int F64_W   = 64;
    localparam int U32_W   = 32;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int EXP_BIAS = 1023;
    localparam logic [3:0] RESV_OK = 4'b1111;

endpackage

// File: rtl/pd2u_ctrl.sv
module pd2u_ctrl
    import pd2u_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [1:0]       vlen,
    input  logic             src_is_mem,
    input  logic             bcst_rc_bit,
    input  logic [1:0]       rm_global,
    input  logic [1:0]       rm_embed,
    input  logic [3:0]       resv_field,
    output rmode_e           rm_eff,
    output logic             use_bcast,
    output logic             fault,
    output logic [LANES-1:0] lane_act
);
    localparam int KW = $clog2(LANES) + 2;

    logic [KW-1:0] kl;
    logic          full_len;

    always_comb begin
        unique case (vlen)
            2'b00:   kl = KW'(2);
            2'b01:   kl = KW'(4);
            default: kl = KW'(8);
        endcase
    end

    assign full_len  = vlen[1];
    assign rm_eff    = (full_len && bcst_rc_bit && !src_is_mem) ? rmode_e'(rm_embed)
                                                               : rmode_e'(rm_global);
    assign use_bcast = src_is_mem && bcst_rc_bit;
    assign fault     = (resv_field != RESV_OK);

    for (genvar j = 0; j < LANES; j++) begin : g_act
        assign lane_act[j] = (KW'(j) < kl);
    end

endmodule

// File: rtl/pd2u_lane.sv
module pd2u_lane
    import pd2u_pkg::*;
(
    input  logic [F64_W-1:0] f_in,
    input  rmode_e           rm,
    output logic [U32_W-1:0] val,
    output logic             inv,
    output logic             inx
);
    localparam int MANT_W  = FRAC_W + 1;
    localparam int FRACX_W = 75;
    localparam int EXT_W   = MANT_W + FRACX_W;
    localparam logic [EXP_W-1:0] E_BIG   = EXP_W'(EXP_BIAS + U32_W);
    localparam logic [EXP_W-1:0] E_SHIFT = EXP_W'(EXP_BIAS + FRAC_W);
    localparam logic [EXP_W-1:0] SH_LIM  = EXP_W'(MANT_W + 1);

    logic              sgn;
    logic [EXP_W-1:0]  ex, e_eff, sh;
    logic [MANT_W-1:0] mant;
    logic              special, big;
    logic [EXT_W-1:0]  ext;
    logic [U32_W:0]    ipart;
    logic              hi_nz, rb, st, inc;
    logic [U32_W+1:0]  mag;
    logic              ovf, neg_bad;

    assign sgn     = f_in[F64_W-1];
    assign ex      = f_in[F64_W-2 -: EXP_W];
    assign mant    = {ex != '0, f_in[FRAC_W-1:0]};
    assign e_eff   = (ex == '0) ? EXP_W'(1) : ex;
    assign special = (ex == '1);
    assign big     = (e_eff >= E_BIG);
    assign sh      = big ? '0 : (E_SHIFT - e_eff);

    // Align the significand: integer part above FRACX_W, guard and sticky below.
    always_comb begin
        if (sh >= SH_LIM) begin
            ext   = '0;
            ipart = '0;
            hi_nz = 1'b0;
            rb    = 1'b0;
            st    = (mant != '0);
        end else begin
            ext   = {mant, {FRACX_W{1'b0}}} >> sh;
            ipart = ext[FRACX_W+U32_W : FRACX_W];
            hi_nz = |ext[EXT_W-1 : FRACX_W+U32_W+1];
            rb    = ext[FRACX_W-1];
            st    = |ext[FRACX_W-2:0];
        end
    end

    always_comb begin
        unique case (rm)
            RM_NEAR: inc = rb & (st | ipart[0]);
            RM_DOWN: inc = sgn & (rb | st);
            RM_UP:   inc = ~sgn & (rb | st);
            RM_ZERO: inc = 1'b0;
        endcase
    end

    assign mag     = {1'b0, ipart} + (U32_W+2)'(inc);
    assign ovf     = hi_nz | mag[U32_W+1] | mag[U32_W];
    assign neg_bad = sgn & (mag != '0);
    assign inv     = special | big | ovf | neg_bad;
    assign inx     = (rb | st) & ~inv;
    assign val     = inv ? '1 : mag[U32_W-1:0];

endmodule

// File: rtl/pd2u_conv.sv
module pd2u_conv
    import pd2u_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*F64_W-1:0] src_vec,
    input  logic [F64_W-1:0]       bcast_val,
    input  logic                   src_is_mem,
    input  logic                   bcst_rc_bit,
    input  logic [1:0]             vlen,
    input  logic                   mask_en,
    input  logic [LANES-1:0]       wr_mask,
    input  logic                   zero_mode,
    input  logic [LANES*U32_W-1:0] prior_dst,
    input  logic [1:0]             rm_global,
    input  logic [1:0]             rm_embed,
    input  logic [3:0]             resv_field,
    output logic [LANES*U32_W-1:0] res_q,
    output logic                   flag_invalid,
    output logic                   flag_inexact,
    output logic                   enc_fault
);
    localparam int RES_W = LANES * U32_W;

    rmode_e           rm_eff;
    logic             use_bcast;
    logic             fault_c;
    logic [LANES-1:0] lane_act;
    logic [LANES-1:0] inv_v, inx_v;
    logic [RES_W-1:0] nxt_res;

    pd2u_ctrl #(.LANES(LANES)) u_ctrl (
        .vlen        (vlen),
        .src_is_mem  (src_is_mem),
        .bcst_rc_bit (bcst_rc_bit),
        .rm_global   (rm_global),
        .rm_embed    (rm_embed),
        .resv_field  (resv_field),
        .rm_eff      (rm_eff),
        .use_bcast   (use_bcast),
        .fault       (fault_c),
        .lane_act    (lane_act)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [F64_W-1:0] op;
        logic [U32_W-1:0] cv;
        logic             ci, cx, wr;

        assign op = use_bcast ? bcast_val : src_vec[j*F64_W +: F64_W];

        pd2u_lane u_lane (
            .f_in (op),
            .rm   (rm_eff),
            .val  (cv),
            .inv  (ci),
            .inx  (cx)
        );

        assign wr = lane_act[j] & (~mask_en | wr_mask[j]);
        assign nxt_res[j*U32_W +: U32_W] =
            !lane_act[j] ? '0 :
            wr           ? cv :
            zero_mode    ? '0 : prior_dst[j*U32_W +: U32_W];
        assign inv_v[j] = wr & ci;
        assign inx_v[j] = wr & cx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q        <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            enc_fault    <= 1'b0;
        end else begin
            res_q        <= nxt_res;
            flag_invalid <= |inv_v;
            flag_inexact <= |inx_v;
            enc_fault    <= fault_c;
        end
    end

endmodule

// File: rtl/pd2u_chk.sv
module pd2u_chk #(
    parameter int LANES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           vlen,
    input logic                 src_is_mem,
    input logic                 bcst_rc_bit,
    input logic                 mask_en,
    input logic [LANES-1:0]     wr_mask,
    input logic                 zero_mode,
    input logic [LANES*32-1:0]  prior_dst,
    input logic [3:0]           resv_field,
    input logic [LANES*32-1:0]  res_q,
    input logic                 flag_invalid,
    input logic                 flag_inexact,
    input logic                 enc_fault
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R10: shortest length leaves every lane above the second at zero
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(vlen) == 2'b00) |-> (res_q[LANES*32-1:64] == '0));

    // R12: fault bit follows the reserved field one cycle later
    p_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (enc_fault == ($past(resv_field) != 4'b1111)));

    // R5: all lanes masked off under the zero policy clears the result
    p_zero_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mask_en && zero_mode && wr_mask == '0)) |-> (res_q == '0));

    // R5: all lanes masked off under merge at full length keeps the prior value
    p_merge_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mask_en && !zero_mode && wr_mask == '0 && vlen[1]))
        |-> (res_q == $past(prior_dst)));

    // R11: no written lane means no flags
    p_flags_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mask_en && wr_mask == '0)) |-> (!flag_invalid && !flag_inexact));

    // R4: unmasked full-length broadcast yields identical lanes
    p_bcast_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(src_is_mem && bcst_rc_bit && !mask_en && vlen[1]))
        |-> (res_q == {LANES{res_q[31:0]}}));

endmodule

bind pd2u_conv pd2u_chk #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vlen         (vlen),
    .src_is_mem   (src_is_mem),
    .bcst_rc_bit  (bcst_rc_bit),
    .mask_en      (mask_en),
    .wr_mask      (wr_mask),
    .zero_mode    (zero_mode),
    .prior_dst    (prior_dst),
    .resv_field   (resv_field),
    .res_q        (res_q),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .enc_fault    (enc_fault)
);

// File: tb/pd2u_conv_bench.sv
`timescale 1ns/1ps
module pd2u_conv_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] src_vec = '0;
    logic [63:0]  bcast_val = '0;
    logic         src_is_mem = 1'b0;
    logic         bcst_rc_bit = 1'b0;
    logic [1:0]   vlen = 2'b10;
    logic         mask_en = 1'b0;
    logic [7:0]   wr_mask = 8'hFF;
    logic         zero_mode = 1'b0;
    logic [255:0] prior_dst = '0;
    logic [1:0]   rm_global = 2'b00;
    logic [1:0]   rm_embed = 2'b00;
    logic [3:0]   resv_field = 4'hF;
    logic [255:0] res_q;
    logic         flag_invalid, flag_inexact, enc_fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pd2u_conv u_pd2u_conv (
        .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .bcast_val(bcast_val),
        .src_is_mem(src_is_mem), .bcst_rc_bit(bcst_rc_bit), .vlen(vlen),
        .mask_en(mask_en), .wr_mask(wr_mask), .zero_mode(zero_mode),
        .prior_dst(prior_dst), .rm_global(rm_global), .rm_embed(rm_embed),
        .resv_field(resv_field), .res_q(res_q), .flag_invalid(flag_invalid),
        .flag_inexact(flag_inexact), .enc_fault(enc_fault)
    );

    // Reference lane: {invalid, inexact, value}
    function automatic logic [33:0] ref_lane(input logic [63:0] b, input logic [1:0] rm);
        real x, fl, cl, r;
        longint lv;
        logic nx;
        if (b[62:52] == 11'h7FF) return {2'b10, 32'hFFFFFFFF};
        x  = $bitstoreal(b);
        fl = $floor(x);
        cl = $ceil(x);
        case (rm)
            2'b00: begin
                if (x - fl < 0.5)      r = fl;
                else if (x - fl > 0.5) r = cl;
                else if ($floor(fl / 2.0) * 2.0 == fl) r = fl;
                else r = cl;
            end
            2'b01:   r = fl;
            2'b10:   r = cl;
            default: r = (x < 0.0) ? cl : fl;
        endcase
        if (r < 0.0 || r >= 4294967296.0) return {2'b10, 32'hFFFFFFFF};
        nx = (r != x);
        lv = longint'(r);
        return {1'b0, nx, lv[31:0]};
    endfunction

    task automatic expect_vals(output logic [255:0] er, output logic ei, output logic ex,
                               output logic ef);
        int kl;
        logic [1:0] rm;
        kl = (vlen == 2'b00) ? 2 : (vlen == 2'b01) ? 4 : 8;
        rm = (vlen[1] && bcst_rc_bit && !src_is_mem) ? rm_embed : rm_global;
        er = '0; ei = 1'b0; ex = 1'b0;
        for (int j = 0; j < 8; j++) begin
            logic [63:0] s;
            logic [33:0] o;
            s = (src_is_mem && bcst_rc_bit) ? bcast_val : src_vec[j*64 +: 64];
            if (j >= kl) er[j*32 +: 32] = '0;
            else if (!mask_en || wr_mask[j]) begin
                o = ref_lane(s, rm);
                er[j*32 +: 32] = o[31:0];
                ei |= o[33];
                ex |= o[32];
            end else begin
                er[j*32 +: 32] = zero_mode ? 32'h0 : prior_dst[j*32 +: 32];
            end
        end
        ef = (resv_field != 4'hF);
    endtask

    task automatic cmp(input string tag, input string what, input logic [255:0] act,
                       input logic [255:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp_v);
        end
    endtask

    logic [255:0] last_er;

    task automatic chk(input string tag);
        logic [255:0] er;
        logic ei, ex, ef;
        @(posedge clk); #1;
        expect_vals(er, ei, ex, ef);
        last_er = er;
        cmp(tag, "result", res_q, er);
        cmp(tag, "invalid", {255'd0, flag_invalid}, {255'd0, ei});
        cmp(tag, "inexact", {255'd0, flag_inexact}, {255'd0, ex});
        cmp(tag, "fault", {255'd0, enc_fault}, {255'd0, ef});
    endtask

    task automatic base();
        vlen = 2'b10; src_is_mem = 1'b0; bcst_rc_bit = 1'b0; mask_en = 1'b0;
        wr_mask = 8'hFF; zero_mode = 1'b0; rm_global = 2'b00; rm_embed = 2'b00;
        resv_field = 4'hF;
        prior_dst = {8{32'hA5A5_5A5A}};
    endtask

    task automatic lanes(input real a0, input real a1, input real a2, input real a3,
                         input real a4, input real a5, input real a6, input real a7);
        src_vec = {$realtobits(a7), $realtobits(a6), $realtobits(a5), $realtobits(a4),
                   $realtobits(a3), $realtobits(a2), $realtobits(a1), $realtobits(a0)};
    endtask

    function automatic logic [63:0] rnd_f64();
        logic [63:0] t, b;
        logic sgn;
        int k;
        t   = {$urandom, $urandom};
        sgn = ($urandom % 4 == 0);
        k   = $urandom % 10;
        case (k)
            0: b = {1'b0, 11'h7FF, ($urandom % 2) ? t[51:0] : 52'd0};
            1: b = {1'b0, 11'd0, t[51:0]};
            2: b = $realtobits(real'($urandom % 64) + 0.5);
            3: b = {1'b0, 11'd1054 + 11'($urandom % 2), t[51:0]};
            default: b = {1'b0, 11'd1010 + 11'($urandom % 46), t[51:0]};
        endcase
        b[63] = sgn;
        return b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        base();
        lanes(1.5, 2.5, 3.0, 4.5, 5.0, 6.5, 7.0, 8.5);
        repeat (3) @(posedge clk);
        #1;
        cmp("R13 reset", "result", res_q, '0);
        cmp("R13 reset", "flags", {253'd0, flag_invalid, flag_inexact, enc_fault}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 nearest with ties to even
        lanes(1.5, 2.5, 3.49, 0.5, 7.5, 1000000000.5, 0.0, 42.0);
        chk("R1 R2 nearest ties");
        // R13 result held until the next edge
        src_vec = '0;
        #1;
        cmp("R13 hold", "result", res_q, last_er);
        lanes(1.5, 2.5, 3.49, 0.5, 7.5, 1000000000.5, 0.0, 42.0);
        rm_global = 2'b01; chk("R2 toward minus");
        rm_global = 2'b10; chk("R2 toward plus");
        rm_global = 2'b11; chk("R2 toward zero");

        // R6 R7 invalid values
        base();
        src_vec = {$realtobits(1.0e20), 64'hFFF0_0000_0000_0000, $realtobits(4294967295.6),
                   $realtobits(4294967295.0), $realtobits(4294967296.0), $realtobits(-1.0),
                   64'h7FF0_0000_0000_0000, 64'h7FF8_0000_0000_0001};
        chk("R6 R7 invalid cases");
        lanes(4294967295.0, 3.0, 0.0, 1.0, 2.0, 9.0, 10.0, 11.0);
        chk("R6 max exact no flags");
        lanes(4294967295.4, 1.0, 0.0, 1.0, 2.0, 9.0, 10.0, 11.0);
        chk("R7 inexact near max");

        // R8 negatives near zero
        base();
        lanes(-0.0, -0.3, -0.5, -0.7, -0.0, -0.0, -0.0, -0.0);
        chk("R8 negative to zero nearest");
        lanes(-0.0, -0.3, -0.5, -0.0, -0.0, -0.0, -0.0, -0.0);
        rm_global = 2'b11; chk("R8 negative truncate");
        rm_global = 2'b01; chk("R8 negative toward minus invalid");

        // R9 subnormals
        base();
        src_vec = {{4{64'h0000_0000_0000_0001}}, {4{64'h8000_0000_0000_0001}}};
        rm_global = 2'b10; chk("R9 subnormal up");
        rm_global = 2'b00; chk("R9 subnormal nearest");
        src_vec = {8{64'h000F_FFFF_FFFF_FFFF}};
        rm_global = 2'b10; chk("R9 subnormal up positive");
        src_vec = {8{64'h800F_FFFF_FFFF_FFFF}};
        rm_global = 2'b01; chk("R9 subnormal down negative");

        // R3 rounding override
        base();
        lanes(1.25, 2.25, 3.25, 4.25, 5.25, 6.25, 7.25, 8.25);
        bcst_rc_bit = 1'b1; rm_embed = 2'b10;
        chk("R3 override at full length");
        vlen = 2'b01; chk("R3 override ignored at 4 lanes");
        vlen = 2'b11; chk("R3 override code 11");

        // R4 broadcast
        base();
        src_is_mem = 1'b1; bcst_rc_bit = 1'b1; rm_embed = 2'b10;
        bcast_val = $realtobits(77.6);
        chk("R4 broadcast full");
        vlen = 2'b01; chk("R4 broadcast 4 lanes");
        bcst_rc_bit = 1'b0; vlen = 2'b10; chk("R4 no broadcast");

        // R5 R11 masking
        base();
        lanes(-2.0, 1.5, 3.0, 0.25, 1.0e12, 6.0, 7.0, 8.0);
        mask_en = 1'b1; wr_mask = 8'b0100_0100;
        chk("R5 R11 merge");
        zero_mode = 1'b1; chk("R5 R11 zero");
        mask_en = 1'b0; chk("R5 mask disabled");
        mask_en = 1'b1; wr_mask = 8'h00; zero_mode = 1'b0; chk("R11 all masked merge");

        // R10 upper lanes zero
        base();
        lanes(1.0, 2.0, 3.0, 4.0, 5.0, 6.0, 7.0, 8.0);
        vlen = 2'b00; mask_en = 1'b1; wr_mask = 8'b1111_1110;
        chk("R10 R1 two lanes");
        vlen = 2'b01; chk("R10 R1 four lanes");

        // R12 fault
        base();
        resv_field = 4'b0111; chk("R12 fault set");
        resv_field = 4'b0000; chk("R12 fault zero field");
        resv_field = 4'b1111; chk("R12 fault clear");

        // Random mix over all requirements
        for (int n = 0; n < 400; n++) begin
            vlen        = 2'($urandom);
            src_is_mem  = 1'($urandom);
            bcst_rc_bit = 1'($urandom);
            mask_en     = 1'($urandom);
            wr_mask     = 8'($urandom);
            zero_mode   = 1'($urandom);
            rm_global   = 2'($urandom);
            rm_embed    = 2'($urandom);
            resv_field  = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            prior_dst   = {$urandom, $urandom, $urandom, $urandom,
                           $urandom, $urandom, $urandom, $urandom};
            for (int j = 0; j < 8; j++) src_vec[j*64 +: 64] = rnd_f64();
            bcast_val = rnd_f64();
            chk("R1-mix random R2 R5 R6 R7");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule